// File: doc/BRIEF.md
# Pulse Burst Generator

The block drives one output pin with a burst of square pulses at 50% duty cycle. Software programs a 16-bit reload value, which sets the half-period, and a 16-bit burst length, which sets how many pulses follow the start. Both values are written and read as separate bytes through a small byte-wide register port. Before starting, software can also set the idle level of the pin. Toggling then begins from that level.

A down-counter is loaded from the reload value and counts one step per clock. Each time it passes zero, it reloads and flips the pin. A divide-by-two stage turns every second flip into a pulse-done strobe, and each strobe decrements the burst length. When the burst length passes zero, the block does three things: it latches a sticky pending flag, clears its own run bit and leaves the pin at its last level. The interrupt request is the pending flag gated by an enable bit.

Top module: `ptg_top`

## Requirements
- R1: After reset, every register reads 0, `pulse_o` is 0 and `irq_o` is 0.
- R2: Address 0 and 1 hold the low and high bytes of the reload value, and addresses 2 and 3 hold the low and high bytes of the burst length. Address 4 is the control register, with bit0 run, bit1 interrupt enable, bit2 pending and bit3 test, and its upper bits read 0. Address 5 bit0 reads the pin level. Every field reads back what was last written or what hardware last set.
- R3: With reload value P, each high time and each low time of the output lasts P+1 clocks. The first toggle occurs P+1 clock edges after the edge that captures the run write.
- R4: With burst length N, exactly N+1 full pulses (2N+2 toggles) are produced. The output then rests at its start level.
- R5: When the burst length is decremented while at 0, the pending bit sets, the run bit clears and the burst length wraps to 0xFFFF.
- R6: The pending bit stays set until software writes 0 to it. If hardware sets it in the same cycle as a software write, the hardware set wins.
- R7: `irq_o` is 1 exactly when both the pending bit and the enable bit are 1.
- R8: A write to address 5 sets the pin to wdata bit0 while run is 0. The write is ignored while run is 1.
- R9: Clearing run freezes the output, the internal down-counter and the burst length. Writing run=1 again reloads the down-counter, resets the divide-by-two stage and continues from the held burst length.
- R10: The test bit is stored and read back but has no effect on the output.
- R11: While running, the output changes only on the clock edge where the internal down-counter is at zero. While stopped, it changes only through a level write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | BYTE_W | Write data |
| rdata | output | BYTE_W | Read data for `addr`, combinational |
| pulse_o | output | 1 | Pulse train output |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench compares the pin cycle by cycle against a count of expected underflows. It covers a reload value of 0 (a toggle every clock) and a reload value above 255 (the high byte in use). A design that decremented the burst length on every toggle instead of every second one would produce about half the pulses. A one-cycle slip in the reload would stretch every half-period. The bench also pauses a burst mid-way and resumes it, and attempts a level write while running. A design that did not reset the divide-by-two stage on restart, or that let the level write through, would show a shifted or inverted waveform. After each burst the bench checks the stop, the 0xFFFF wrap, the sticky pending bit and the interrupt gating, which catches a design that keeps running past the end or clears pending on its own.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_PRE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PRE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_LEVEL  = 3'd5;

    // control nibble bit positions
    localparam int B_RUN  = 0;
    localparam int B_IEN  = 1;
    localparam int B_IPND = 2;
    localparam int B_TM   = 3;
endpackage

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [CNT_W-1:0] reload,
    output logic             uf,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        uf    = 1'b0;
        if (start) begin
            cnt_d = reload;
        end else if (run) begin
            if (cnt_q == '0) begin
                uf    = 1'b1;
                cnt_d = reload;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ptg_halfstage.sv
module ptg_halfstage (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic uf,
    input  logic run,
    input  logic lvl_wr,
    input  logic lvl_val,
    output logic pulse,
    output logic strobe
);
    typedef struct packed {
        logic half;
        logic out;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d   = hs_q;
        strobe = uf & hs_q.half;
        if (start) begin
            hs_d.half = 1'b0;
        end else if (uf) begin
            hs_d.half = ~hs_q.half;
            hs_d.out  = ~hs_q.out;
        end
        if (lvl_wr && !run) begin
            hs_d.out = lvl_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign pulse = hs_q.out;
endmodule

// File: rtl/ptg_count_step.sv
module ptg_count_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] next,
    output logic         wrap
);
    assign wrap = (value == '0);
    assign next = value - 1'b1;
endmodule

// File: rtl/ptg_top.sv
module ptg_top
    import ptg_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              pulse_o,
    output logic              irq_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             run;
        logic             ien;
        logic             ipnd;
        logic             tm;
    } regs_t;

    regs_t st_d, st_q;

    logic             ctrl_wr, lvl_wr, start;
    logic             pre_uf, strobe, wrap, hw_set;
    logic [CNT_W-1:0] pre_cnt, cnt_next;
    logic             run_q, ien_q, ipnd_q;

    assign run_q   = st_q.run;
    assign ien_q   = st_q.ien;
    assign ipnd_q  = st_q.ipnd;
    assign ctrl_wr = wr_en && (addr == ADR_CTRL);
    assign lvl_wr  = wr_en && (addr == ADR_LEVEL);
    assign start   = ctrl_wr && wdata[B_RUN];

    ptg_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .start  (start),
        .reload (st_q.reload),
        .uf     (pre_uf),
        .cnt    (pre_cnt)
    );

    ptg_halfstage u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .uf      (pre_uf),
        .run     (run_q),
        .lvl_wr  (lvl_wr),
        .lvl_val (wdata[0]),
        .pulse   (pulse_o),
        .strobe  (strobe)
    );

    ptg_count_step #(.W(CNT_W)) u_step (
        .value (st_q.count),
        .next  (cnt_next),
        .wrap  (wrap)
    );

    assign hw_set = strobe && wrap;

    always_comb begin
        st_d = st_q;
        if (strobe) begin
            st_d.count = cnt_next;
            if (wrap) begin
                st_d.ipnd = 1'b1;
                st_d.run  = 1'b0;
            end
        end
        if (wr_en) begin
            case (addr)
                ADR_PRE_LO: st_d.reload[BYTE_W-1:0]     = wdata;
                ADR_PRE_HI: st_d.reload[CNT_W-1:BYTE_W] = wdata;
                ADR_CNT_LO: st_d.count[BYTE_W-1:0]      = wdata;
                ADR_CNT_HI: st_d.count[CNT_W-1:BYTE_W]  = wdata;
                ADR_CTRL: begin
                    st_d.run  = wdata[B_RUN];
                    st_d.ien  = wdata[B_IEN];
                    st_d.tm   = wdata[B_TM];
                    st_d.ipnd = wdata[B_IPND] | hw_set;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_PRE_LO: rdata = st_q.reload[BYTE_W-1:0];
            ADR_PRE_HI: rdata = st_q.reload[CNT_W-1:BYTE_W];
            ADR_CNT_LO: rdata = st_q.count[BYTE_W-1:0];
            ADR_CNT_HI: rdata = st_q.count[CNT_W-1:BYTE_W];
            ADR_CTRL: begin
                rdata[B_RUN]  = st_q.run;
                rdata[B_IEN]  = st_q.ien;
                rdata[B_IPND] = st_q.ipnd;
                rdata[B_TM]   = st_q.tm;
            end
            ADR_LEVEL: rdata[0] = pulse_o;
            default: rdata = '0;
        endcase
    end

    assign irq_o = ipnd_q & ien_q;
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_q,
    input logic             ien_q,
    input logic             ipnd_q,
    input logic             ctrl_wr,
    input logic             lvl_wr,
    input logic             pulse_o,
    input logic             irq_o,
    input logic [CNT_W-1:0] pre_cnt
);
    AST_TOGGLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && pre_cnt != '0) |=> $stable(pulse_o)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !lvl_wr) |=> $stable(pulse_o)); // R9

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ipnd_q && !ctrl_wr) |=> ipnd_q); // R6

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ipnd_q) && !$past(ctrl_wr)) |-> !run_q); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ien_q); // R7

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !ipnd_q |-> !irq_o); // R7
endmodule

bind ptg_top ptg_checker #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .ien_q   (ien_q),
    .ipnd_q  (ipnd_q),
    .ctrl_wr (ctrl_wr),
    .lvl_wr  (lvl_wr),
    .pulse_o (pulse_o),
    .irq_o   (irq_o),
    .pre_cnt (pre_cnt)
);

// File: tb/ptg_top_tb_top.sv
`timescale 1ns/1ps
module ptg_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pulse_o, irq_o;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ptg_top #(.BYTE_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pulse_o(pulse_o), .irq_o(irq_o)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int exp_toggles(int k, int pr, int ct);
        int t = k / (pr + 1);
        int lim = 2 * (ct + 1);
        return (t > lim) ? lim : t;
    endfunction

    task automatic burst(logic [15:0] pr, logic [15:0] ct, bit lvl, bit ien);
        int kend, mism, bad_k, bad_v;
        logic [7:0] lo, hi, c;
        wr(3'd0, pr[7:0]); wr(3'd1, pr[15:8]);
        wr(3'd2, ct[7:0]); wr(3'd3, ct[15:8]);
        wr(3'd5, {7'b0, lvl});
        chk(pulse_o == lvl, "R8", "level write while stopped", pulse_o, lvl);
        wr(3'd4, {6'b0, ien, 1'b1});
        kend = 2 * (int'(ct) + 1) * (int'(pr) + 1);
        mism = 0; bad_k = 0; bad_v = 0;
        for (int k = 1; k <= kend + 3; k++) begin
            @(negedge clk);
            if (k == 2 && kend >= 4) begin
                wr_en = 1'b1; addr = 3'd5; wdata = {7'b0, ~lvl};
            end else if (k == 3) begin
                wr_en = 1'b0;
            end
            if (pulse_o != (lvl ^ exp_toggles(k, int'(pr), int'(ct)) [0])) begin
                if (mism == 0) begin bad_k = k; bad_v = pulse_o; end
                mism++;
            end
        end
        // R3 R4 R8: waveform, pulse count, level write ignored while running
        chk(mism == 0, "R3 R4 R8", $sformatf("waveform pr=%0d ct=%0d first bad cycle %0d", pr, ct, bad_k),
            bad_v, mism == 0 ? bad_v : ~bad_v & 1);
        chk(pulse_o == lvl, "R4", "rest level after burst", pulse_o, lvl);
        rd(3'd4, c);
        chk(c[0] == 1'b0, "R5", "run cleared at end", c[0], 0);
        chk(c[2] == 1'b1, "R5", "pending set at end", c[2], 1);
        rd(3'd2, lo); rd(3'd3, hi);
        chk({hi, lo} == 16'hFFFF, "R5", "count wraps", {hi, lo}, 16'hFFFF);
        chk(irq_o == ien, "R7", "irq gated by enable", irq_o, ien);
        repeat (5) @(negedge clk);
        rd(3'd4, c);
        chk(c[2] == 1'b1, "R6", "pending sticky", c[2], 1);
        wr(3'd4, 8'h00);
        rd(3'd4, c);
        chk(c[2] == 1'b0 && irq_o == 1'b0, "R6", "pending cleared by write", {c[2], irq_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int mism;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk(d == 8'h00, "R1", $sformatf("reset value addr %0d", a), d, 0);
        end
        chk(pulse_o == 1'b0 && irq_o == 1'b0, "R1", "reset outputs", {pulse_o, irq_o}, 0);

        // R2 register readback
        wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
        rd(3'd0, d); chk(d == 8'hA5, "R2", "reload low", d, 8'hA5);
        rd(3'd1, d); chk(d == 8'h3C, "R2", "reload high", d, 8'h3C);
        rd(3'd2, d); chk(d == 8'h5A, "R2", "count low", d, 8'h5A);
        rd(3'd3, d); chk(d == 8'hC3, "R2", "count high", d, 8'hC3);
        // R10: test bit stored, no effect; upper bits dropped
        wr(3'd4, 8'hFE);
        rd(3'd4, d); chk(d == 8'h0E, "R2 R10", "control readback", d, 8'h0E);
        chk(irq_o == 1'b1, "R7", "irq with pending and enable", irq_o, 1);
        repeat (10) @(negedge clk);
        chk(pulse_o == 1'b0, "R10", "test bit leaves output idle", pulse_o, 0);
        wr(3'd4, 8'h00);
        chk(irq_o == 1'b0, "R7", "irq drops", irq_o, 0);

        // directed corners
        burst(16'd0, 16'd0, 1'b1, 1'b1);
        burst(16'd0, 16'd3, 1'b0, 1'b0);
        burst(16'd256, 16'd0, 1'b0, 1'b1);
        burst(16'd5, 16'd2, 1'b1, 1'b1);
        // random bursts
        for (int i = 0; i < 8; i++) begin
            burst(16'($urandom_range(0, 6)), 16'($urandom_range(0, 4)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        // R9 pause and resume: reload 3, length 3, level 0
        wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'd3); wr(3'd3, 8'd0); wr(3'd5, 8'd0);
        wr(3'd4, 8'h01);
        for (int k = 1; k <= 10; k++) @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 8'h00;   // captured on edge 11
        @(negedge clk);
        wr_en = 1'b0;
        mism = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pulse_o != 1'b0) mism++;
        end
        chk(mism == 0, "R9", "output frozen while paused", mism, 0);
        rd(3'd2, d);
        chk(d == 8'd2, "R9", "count held while paused", d, 2);
        wr(3'd4, 8'h01);
        mism = 0;
        for (int k = 1; k <= 27; k++) begin
            @(negedge clk);
            if (pulse_o != exp_toggles(k, 3, 2) [0]) mism++;
        end
        chk(mism == 0, "R9", "resume restarts divide stage", mism, 0);
        rd(3'd4, d);
        chk(d[0] == 1'b0 && d[2] == 1'b1, "R9", "resumed burst finishes", d[2:0], 3'b100);
        wr(3'd4, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule